// File: doc/BRIEF.md
# Hierarchical Vertical Clock Sequencer for an Image Sensor

The block drives six vertical transfer clock phases that move sensor lines, one at a time, toward the horizontal output register. Two strobes come with them: a line blanking strobe and a clamp strobe. The waveform is built from four programmable tables. These are walked on the fly. Pattern groups give each phase a start level and two toggle points. Sequences pick a pattern group and add a start pixel, a repeat count and strobe enables. Fields split the frame into line regions, and each region names a sequence. A mode list gives the order in which fields are played.

A pixel clock runs the block. A line sync pulse starts each line, and a frame sync pulse starts each field. Software writes every table through a single-cycle write port. Writes land in a staging copy. That copy is moved into the working copy on the next frame sync, so a field never mixes old and new settings. While no usable mode entry exists, the phases rest at programmed idle levels and blanking stays high.

Top module: `ccd_vseq`

## Requirements
- R1: After reset the phase outputs are all low, blank is high and clamp is low, and this holds until the first frame sync.
- R2: While no frame sync has been seen since reset, or the active mode length is 0, or the selected field number is 6 or more, or the sequence or pattern index is out of range, the phases equal the active idle levels, blank is high and clamp is low.
- R3: Register writes change only the staging copy. The active copy takes the staging values at each frame sync, so outputs within a field follow only the settings active at its start.
- R4: Each frame sync sets the line count to 0 and steps the mode index to the next entry. The index wraps to entry 0 after the last entry (index length-1). The index also restarts at 0 after a frame with no valid length. The same field may appear in several entries.
- R5: Region 0 starts at line 0. Region r (1 to count-1) starts at its stored line. The region in effect is the highest-numbered region whose start is at or below the current line.
- R6: While a pattern repetition is running at position q (0 to length-1), phase k (bit k of the output, bit 0 is the first phase) equals init[k] XOR (q >= first toggle) XOR (q >= second toggle). A pattern length of 0 acts as 1.
- R7: A sequence plays its pattern exactly N back-to-back times, starting at its start pixel (counted from 0 at line sync). Before and after that window the phases hold the pattern's init levels. N = 0 plays nothing.
- R8: With its enable set, blank is high from line start until the last repetition ends. With its enable set, clamp is high from the pixel after the last repetition (or all line if N = 0) to line end. The two are never high together.
- R9: The outputs for pixel p of a line are visible after the (p+1)th rising edge following the edge that samples the line or frame sync.
- R10: Write map (addr[7:4] class, addr[3:0] index). Class 0, pattern i: data[11:0] length, data[21:16] init levels. Classes 1 to 6, phase class-1 of pattern i: data[11:0] first toggle, data[27:16] second toggle. Class 7, sequence i: data[3:0] pattern, data[15:4] start pixel, data[23:16] repeat count, data[24] blank enable, data[25] clamp enable. Class 8+f, field f: index r<7 gives data[11:0] start line and data[19:16] sequence; index 15 gives data[2:0] region count. Class 15: index e<7 gives data[2:0] field of entry e; index 14 gives data[2:0] mode length; index 15 gives data[5:0] idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_sync | input | 1 | Starts a new line (pixel count to 0) |
| frame_sync | input | 1 | Starts a new field at line 0 and loads the active copy |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address: class and index |
| wr_data | input | 32 | Write data |
| vphase | output | 6 | Vertical transfer clock phases, bit 0 first phase |
| blank | output | 1 | Line blanking strobe |
| clamp | output | 1 | Clamp strobe |

## Verification
Each output is due one register stage after its pixel. The bench drives a sync at a falling edge, and the next rising edge samples it. To read pixel p, the bench then waits p+1 further falling edges before comparing. It also keeps a running pixel cursor, so several pixels of one line are checked in rising order without losing count. Register writes are checked twice: once before the frame sync that should apply them, with no change expected, and again in the field that follows. The frame sync that moves the mode index is checked from the first pixels of the new field.

// File: rtl/ccd_vseq.sv
module ccd_vseq #(
  parameter int NPAT  = 10,
  parameter int NSEQ  = 10,
  parameter int NFLD  = 6,
  parameter int NREG  = 7,
  parameter int NMODE = 7,
  parameter int CW    = 12,
  parameter int LW    = 12,
  parameter int RW    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        line_sync,
  input  logic        frame_sync,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  output logic [5:0]  vphase,
  output logic        blank,
  output logic        clamp
);
  localparam int NPH = 6;
  localparam int PHW = 3;
  localparam int PIW = $clog2(NPAT);
  localparam int SIW = $clog2(NSEQ);
  localparam int FIW = $clog2(NFLD + 1);
  localparam int FAW = $clog2(NFLD);
  localparam int RIW = $clog2(NREG);
  localparam int RCW = $clog2(NREG + 1);
  localparam int MIW = $clog2(NMODE);
  localparam int MLW = $clog2(NMODE + 1);

  logic [CW-1:0]  sh_plen [NPAT], ac_plen [NPAT];
  logic [NPH-1:0] sh_init [NPAT], ac_init [NPAT];
  logic [CW-1:0]  sh_ta [NPAT][NPH], ac_ta [NPAT][NPH];
  logic [CW-1:0]  sh_tb [NPAT][NPH], ac_tb [NPAT][NPH];
  logic [PIW-1:0] sh_spat [NSEQ], ac_spat [NSEQ];
  logic [CW-1:0]  sh_sst [NSEQ], ac_sst [NSEQ];
  logic [RW-1:0]  sh_srep [NSEQ], ac_srep [NSEQ];
  logic           sh_sbl [NSEQ], ac_sbl [NSEQ];
  logic           sh_scl [NSEQ], ac_scl [NSEQ];
  logic [LW-1:0]  sh_rst [NFLD][NREG], ac_rst [NFLD][NREG];
  logic [SIW-1:0] sh_rseq [NFLD][NREG], ac_rseq [NFLD][NREG];
  logic [RCW-1:0] sh_rcnt [NFLD], ac_rcnt [NFLD];
  logic [FIW-1:0] sh_mode [NMODE], ac_mode [NMODE];
  logic [MLW-1:0] sh_len, ac_len;
  logic [NPH-1:0] sh_idle, ac_idle;

  wire [3:0] cls = wr_addr[7:4];
  wire [3:0] idx = wr_addr[3:0];
  wire unused_data = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAT; i++) begin
        sh_plen[i] <= '0;
        sh_init[i] <= '0;
        for (int k = 0; k < NPH; k++) begin
          sh_ta[i][k] <= '0;
          sh_tb[i][k] <= '0;
        end
      end
      for (int i = 0; i < NSEQ; i++) begin
        sh_spat[i] <= '0;
        sh_sst[i]  <= '0;
        sh_srep[i] <= '0;
        sh_sbl[i]  <= 1'b0;
        sh_scl[i]  <= 1'b0;
      end
      for (int f = 0; f < NFLD; f++) begin
        sh_rcnt[f] <= '0;
        for (int r = 0; r < NREG; r++) begin
          sh_rst[f][r]  <= '0;
          sh_rseq[f][r] <= '0;
        end
      end
      for (int e = 0; e < NMODE; e++) sh_mode[e] <= '0;
      sh_len  <= '0;
      sh_idle <= '0;
    end else if (wr_en) begin
      if (cls == 4'd0 && int'(idx) < NPAT) begin
        sh_plen[PIW'(idx)] <= wr_data[CW-1:0];
        sh_init[PIW'(idx)] <= wr_data[16 +: NPH];
      end
      if (cls >= 4'd1 && int'(cls) <= NPH && int'(idx) < NPAT) begin
        sh_ta[PIW'(idx)][PHW'(cls - 4'd1)] <= wr_data[CW-1:0];
        sh_tb[PIW'(idx)][PHW'(cls - 4'd1)] <= wr_data[16 +: CW];
      end
      if (cls == 4'd7 && int'(idx) < NSEQ) begin
        sh_spat[SIW'(idx)] <= wr_data[PIW-1:0];
        sh_sst[SIW'(idx)]  <= wr_data[4 +: CW];
        sh_srep[SIW'(idx)] <= wr_data[16 +: RW];
        sh_sbl[SIW'(idx)]  <= wr_data[24];
        sh_scl[SIW'(idx)]  <= wr_data[25];
      end
      if (cls >= 4'd8 && int'(cls) < 8 + NFLD) begin
        if (idx == 4'd15)
          sh_rcnt[FAW'(cls - 4'd8)] <= wr_data[RCW-1:0];
        else if (int'(idx) < NREG) begin
          sh_rst[FAW'(cls - 4'd8)][RIW'(idx)]  <= wr_data[LW-1:0];
          sh_rseq[FAW'(cls - 4'd8)][RIW'(idx)] <= wr_data[16 +: SIW];
        end
      end
      if (cls == 4'd15) begin
        if (int'(idx) < NMODE) sh_mode[MIW'(idx)] <= wr_data[FIW-1:0];
        else if (idx == 4'd14) sh_len <= wr_data[MLW-1:0];
        else if (idx == 4'd15) sh_idle <= wr_data[NPH-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPAT; i++) begin
        ac_plen[i] <= '0;
        ac_init[i] <= '0;
        for (int k = 0; k < NPH; k++) begin
          ac_ta[i][k] <= '0;
          ac_tb[i][k] <= '0;
        end
      end
      for (int i = 0; i < NSEQ; i++) begin
        ac_spat[i] <= '0;
        ac_sst[i]  <= '0;
        ac_srep[i] <= '0;
        ac_sbl[i]  <= 1'b0;
        ac_scl[i]  <= 1'b0;
      end
      for (int f = 0; f < NFLD; f++) begin
        ac_rcnt[f] <= '0;
        for (int r = 0; r < NREG; r++) begin
          ac_rst[f][r]  <= '0;
          ac_rseq[f][r] <= '0;
        end
      end
      for (int e = 0; e < NMODE; e++) ac_mode[e] <= '0;
      ac_len  <= '0;
      ac_idle <= '0;
    end else if (frame_sync) begin
      ac_plen <= sh_plen;
      ac_init <= sh_init;
      ac_ta   <= sh_ta;
      ac_tb   <= sh_tb;
      ac_spat <= sh_spat;
      ac_sst  <= sh_sst;
      ac_srep <= sh_srep;
      ac_sbl  <= sh_sbl;
      ac_scl  <= sh_scl;
      ac_rst  <= sh_rst;
      ac_rseq <= sh_rseq;
      ac_rcnt <= sh_rcnt;
      ac_mode <= sh_mode;
      ac_len  <= sh_len;
      ac_idle <= sh_idle;
    end
  end

  logic [CW-1:0]  pix, ppos;
  logic [LW-1:0]  line;
  logic [RW-1:0]  prep;
  logic [MIW-1:0] midx;
  logic           started, done;

  logic [FIW-1:0] fnum;
  logic [FAW-1:0] fs;
  logic [RIW-1:0] rsel;
  logic [SIW-1:0] snum, ss;
  logic [PIW-1:0] pnum, pp;
  logic           mode_ok, seq_ok, pat_ok, cfg_ok, run, fin;
  logic [CW-1:0]  plen_e, st;
  logic [RW-1:0]  nrep;
  logic [NPH-1:0] lev;

  assign fnum    = ac_mode[midx];
  assign mode_ok = started && ac_len != '0 && int'(fnum) < NFLD;
  assign fs      = mode_ok ? FAW'(fnum) : '0;

  always_comb begin
    rsel = '0;
    for (int r = 1; r < NREG; r++)
      if (r < int'(ac_rcnt[fs]) && ac_rst[fs][r] <= line) rsel = RIW'(r);
  end

  assign snum   = ac_rseq[fs][rsel];
  assign seq_ok = int'(snum) < NSEQ;
  assign ss     = seq_ok ? snum : '0;
  assign pnum   = ac_spat[ss];
  assign pat_ok = int'(pnum) < NPAT;
  assign pp     = pat_ok ? pnum : '0;
  assign cfg_ok = mode_ok && seq_ok && pat_ok;
  assign plen_e = (ac_plen[pp] == '0) ? CW'(1) : ac_plen[pp];
  assign nrep   = ac_srep[ss];
  assign st     = ac_sst[ss];
  assign run    = cfg_ok && !done && nrep != '0 && pix >= st;
  assign fin    = done || nrep == '0;

  always_comb
    for (int k = 0; k < NPH; k++)
      lev[k] = ac_init[pp][k] ^ (ppos >= ac_ta[pp][k]) ^ (ppos >= ac_tb[pp][k]);

  wire line_start = line_sync || frame_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix <= '0; ppos <= '0; prep <= '0; done <= 1'b0;
    end else if (line_start) begin
      pix <= '0; ppos <= '0; prep <= '0; done <= 1'b0;
    end else begin
      if (pix != '1) pix <= pix + CW'(1);
      if (run) begin
        if (ppos == plen_e - CW'(1)) begin
          ppos <= '0;
          if (prep == nrep - RW'(1)) done <= 1'b1;
          else prep <= prep + RW'(1);
        end else
          ppos <= ppos + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0; midx <= '0; started <= 1'b0;
    end else if (frame_sync) begin
      line    <= '0;
      started <= 1'b1;
      if (!started || ac_len == '0 || int'(midx) + 1 >= int'(sh_len)) midx <= '0;
      else midx <= midx + MIW'(1);
    end else if (line_sync)
      line <= line + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vphase <= '0; blank <= 1'b1; clamp <= 1'b0;
    end else if (cfg_ok) begin
      vphase <= run ? lev : ac_init[pp];
      blank  <= ac_sbl[ss] && !fin;
      clamp  <= ac_scl[ss] && fin;
    end else begin
      vphase <= ac_idle; blank <= 1'b1; clamp <= 1'b0;
    end
  end

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst) !(blank && clamp));
  // R4
  line_reset_chk: assert property (@(posedge clk) disable iff (rst) frame_sync |=> (line == '0 && pix == '0));
  // R4
  mode_range_chk: assert property (@(posedge clk) disable iff (rst) (started && ac_len != '0) |-> int'(midx) < int'(ac_len));
  // R3
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst) !frame_sync |=> ($stable(ac_len) && $stable(ac_idle)));
  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (rst) !cfg_ok |=> (vphase == $past(ac_idle) && blank && !clamp));
  // R7
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst) ppos < plen_e);
endmodule

// File: tb/ccd_vseq_test.sv
module ccd_vseq_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic line_sync = 1'b0, frame_sync = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [5:0]  vphase;
  logic        blank, clamp;
  int checks = 0, fails = 0, cur = -1, cur_line = 0;

  always #4 clk = ~clk;

  ccd_vseq uut (.clk(clk), .rst(rst), .line_sync(line_sync), .frame_sync(frame_sync),
                .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                .vphase(vphase), .blank(blank), .clamp(clamp));

  // {line[3:0], pixel[7:0], vphase[5:0], blank, clamp} for field 0
  localparam logic [19:0] VEC [14] = '{
    {4'd0, 8'd0, 6'b001000, 1'b1, 1'b0},
    {4'd0, 8'd1, 6'b000000, 1'b1, 1'b0},
    {4'd0, 8'd5, 6'b000000, 1'b1, 1'b0},
    {4'd0, 8'd6, 6'b000000, 1'b0, 1'b0},
    {4'd1, 8'd4, 6'b001000, 1'b1, 1'b0},
    {4'd2, 8'd1, 6'b000011, 1'b1, 1'b0},
    {4'd2, 8'd2, 6'b000011, 1'b1, 1'b0},
    {4'd2, 8'd3, 6'b000010, 1'b1, 1'b0},
    {4'd2, 8'd4, 6'b000110, 1'b1, 1'b0},
    {4'd2, 8'd5, 6'b000111, 1'b1, 1'b0},
    {4'd2, 8'd6, 6'b000011, 1'b0, 1'b1},
    {4'd3, 8'd3, 6'b000010, 1'b1, 1'b0},
    {4'd4, 8'd0, 6'b000011, 1'b0, 1'b1},
    {4'd4, 8'd9, 6'b000011, 1'b0, 1'b1}
  };

  task automatic chk(input string tag, input logic [5:0] ev, input logic eb, input logic ec);
    checks++;
    if (vphase !== ev || blank !== eb || clamp !== ec) begin
      fails++;
      $display("FAIL %s: vphase=%b blank=%b clamp=%b expected vphase=%b blank=%b clamp=%b",
               tag, vphase, blank, clamp, ev, eb, ec);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start_line(input logic fs);
    line_sync = 1'b1; frame_sync = fs;
    @(negedge clk);
    line_sync = 1'b0; frame_sync = 1'b0;
    cur = -1;
    if (fs) cur_line = 0; else cur_line++;
  endtask

  task automatic go_pix(input int p);
    repeat (p - cur) @(negedge clk);
    cur = p;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset state", 6'b000000, 1'b1, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle before first frame", 6'b000000, 1'b1, 1'b0);

    wr(8'hFF, 32'h0000_002A);
    wr(8'hFE, 32'h0000_0000);
    repeat (2) @(negedge clk);
    chk("R3 idle write staged", 6'b000000, 1'b1, 1'b0);

    start_line(1'b1);
    go_pix(0);
    chk("R2 mode length 0 gives idle", 6'b101010, 1'b1, 1'b0);

    // R10 table contents
    wr(8'h00, 32'h0003_0004);
    wr(8'h10, 32'h0003_0001);
    wr(8'h30, 32'h0FFF_0002);
    wr(8'h01, 32'h0000_0002);
    wr(8'h41, 32'h0001_0000);
    wr(8'h70, 32'h0301_0020);
    wr(8'h71, 32'h0103_0001);
    wr(8'h72, 32'h0200_0050);
    wr(8'h80, 32'h0001_0000);
    wr(8'h81, 32'h0000_0002);
    wr(8'h82, 32'h0002_0004);
    wr(8'h8F, 32'h0000_0003);
    wr(8'h90, 32'h0000_0000);
    wr(8'h9F, 32'h0000_0001);
    wr(8'hF0, 32'h0000_0000);
    wr(8'hF1, 32'h0000_0001);
    wr(8'hF2, 32'h0000_0000);
    wr(8'hFE, 32'h0000_0003);
    @(negedge clk);
    chk("R3 config staged until frame sync", 6'b101010, 1'b1, 1'b0);

    start_line(1'b1);
    for (int i = 0; i < 14; i++) begin
      while (cur_line < int'(VEC[i][19:16])) start_line(1'b0);
      go_pix(int'(VEC[i][15:8]));
      chk($sformatf("R5 R6 R7 R8 R9 R10 vector %0d", i), VEC[i][7:2], VEC[i][1], VEC[i][0]);
    end

    start_line(1'b1);
    go_pix(3);
    chk("R4 second entry plays field 1", 6'b000010, 1'b1, 1'b0);
    wr(8'h70, 32'h0301_0030);
    start_line(1'b0);
    go_pix(3);
    chk("R3 mid-field write not applied", 6'b000010, 1'b1, 1'b0);

    start_line(1'b1);
    go_pix(0);
    chk("R4 third entry repeats field 0", 6'b001000, 1'b1, 1'b0);
    start_line(1'b0);
    start_line(1'b0);
    go_pix(3);
    chk("R3 new start pixel applied", 6'b000011, 1'b1, 1'b0);
    go_pix(4);
    chk("R3 R7 shifted window", 6'b000010, 1'b1, 1'b0);

    start_line(1'b1);
    go_pix(0);
    chk("R4 wrap to entry 0", 6'b001000, 1'b1, 1'b0);

    start_line(1'b1);
    go_pix(0);
    chk("R4 entry 1 after wrap", 6'b000011, 1'b1, 1'b0);

    wr(8'hF0, 32'h0000_0007);
    wr(8'hFE, 32'h0000_0001);
    start_line(1'b1);
    go_pix(2);
    chk("R2 field number out of range gives idle", 6'b101010, 1'b1, 1'b0);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule